// File: doc/BRIEF.md
# Serial Multi-Channel DAC Register Controller

This block is the digital front end of a twelve-channel, 8-bit digital-to-analog converter. A host sends 16-bit command frames over a three-wire serial link: an active-low chip-select that frames the transfer, a shift clock and a data input. The controller shifts each frame into a 16-bit register and drives the bit leaving that register on a serial data output, so several devices can be chained in a daisy chain. The shift clock, data input and chip-select are asynchronous to the system clock. They are synchronized and edge-detected before any logic uses them.

When chip-select rises after exactly sixteen clocks, the frame is decoded. The low four bits choose a target. The result is one of the following: a code written to one of twelve 8-bit channel registers, a level sent to every channel at once, the eight shared channels (5 to 12) released to high impedance for the port expander, or a soft reset. Targets 13 to 15 belong to the port expander. For these, the block issues a one-cycle strobe that carries the target and the 12-bit payload.

The outputs are the twelve code registers, as one flat vector, and one high-impedance flag for each shared channel.

Top module: `dac_frame_ctrl`

## Requirements
- R1: Frames are shifted least significant bit first, on rising shift-clock edges seen while chip-select is low. Frame bits 3:0 are the target and bits 15:4 are the setting. Bits 15:12 are the opcode and bits 11:4 are the code.
- R2: A frame takes effect only when chip-select rises after exactly 16 shift clocks. With any other count (for example 15 or 17), no output changes.
- R3: Targets 1 to 12 with opcode 0 load the code into channel n, at dac_code bits [(n-1)*8 +: 8]. For a shared channel (5 to 12), this also clears its flag at shared_hiz bit n-5.
- R4: Targets 1 to 12 with setting 0x100 set the shared_hiz flag of channels 5 to 12 and leave their codes alone. On channels 1 to 4 this setting has no effect. Any other setting with a nonzero opcode is ignored.
- R5: Target 0 with opcode 1 writes the code to all twelve channels and clears every shared_hiz flag.
- R6: Target 0 with opcode 2 sets all eight shared_hiz flags and leaves every code unchanged.
- R7: Target 0 with opcode 3 is a soft reset: all codes become 0 and all shared_hiz flags become 1. Target 0 with any other opcode is ignored.
- R8: Targets 13, 14 and 15 change no channel state. Each raises exp_vld for one system cycle, with exp_op equal to target bits 1:0 (01, 10 and 11) and exp_payload equal to frame bits 15:4.
- R9: sdo carries bit 0 of the shift register. It is loaded when chip-select falls and reloaded on each falling shift-clock edge. So during a frame, sdo carries the previous frame's bits in order. sdo_oe is low while chip-select is high and high while it is low.
- R10: The synchronous reset sets all codes to 0 and all shared_hiz flags to 1. It clears shift register bits 15:8 and keeps bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial shift clock (asynchronous) |
| sdi_in | input | 1 | Serial data input (asynchronous) |
| csn_in | input | 1 | Active-low chip-select (asynchronous) |
| sdo | output | 1 | Serial data output for chaining |
| sdo_oe | output | 1 | Output enable for sdo |
| dac_code | output | 96 | Twelve 8-bit channel codes, channel 1 in bits 7:0 |
| shared_hiz | output | 8 | High-impedance flag, channels 5 to 12 |
| exp_vld | output | 1 | One-cycle expander command strobe |
| exp_op | output | 2 | Expander command, from target bits 1:0 |
| exp_payload | output | 12 | Frame bits 15:4 for the expander |

## Verification
Single-channel writes go to one unshared channel and to two shared channels. The code values are asymmetric, so a reversed bit order or a wrong channel index gives a different register image. Broadcast, all-shared high impedance, soft reset and ignored opcodes are sent between those writes, so each can be told apart from the state left by the previous frame. A high-impedance request is sent to an unshared channel, and another frame carries a nonzero opcode with an unrecognised setting; both must leave the image unchanged. Frames of 15 and 17 clocks check the length rule. Two frames sent back to back check the chained output, and a reset placed between frames shows which half of the shift register survives.

// File: rtl/dacf_pkg.sv
package dacf_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_ONE,
    UPD_HIZ1,
    UPD_ALL,
    UPD_HIZALL,
    UPD_RST
  } upd_kind_t;

  typedef struct packed {
    upd_kind_t         kind;
    logic [SEL_W-1:0]  idx;
    logic [CODE_W-1:0] code;
  } upd_t;
endpackage

// File: rtl/dacf_sync.sv
module dacf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {(STAGES+1){RST_VAL}};
    else     pipe <= {pipe[STAGES-1:0], d};
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/dacf_shift.sv
module dacf_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_high,
  input  logic               cs_fall,
  input  logic               cs_rise,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_vld,
  output logic               dout,
  output logic               dout_oe
);
  localparam int HALF  = FRAME_W / 2;
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:HALF] hi_q;
  logic [HALF-1:0]       lo_q;
  logic [CNT_W-1:0]      cnt;
  logic                  shift_en;
  logic                  dout_q;

  assign shift_en = sclk_rise & ~cs_high;

  // upper half is cleared by reset, lower half keeps its content
  always_ff @(posedge clk) begin
    if (rst)           hi_q <= '0;
    else if (shift_en) hi_q <= {din, hi_q[FRAME_W-1:HALF+1]};
  end

  always_ff @(posedge clk) begin
    if (!rst && shift_en) lo_q <= {hi_q[HALF], lo_q[HALF-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (cs_fall)              cnt <= '0;
    else if (shift_en && cnt != OVER) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) frame_vld <= 1'b0;
    else     frame_vld <= cs_rise && (cnt == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst)                            dout_q <= 1'b0;
    else if (cs_fall)                   dout_q <= lo_q[0];
    else if (sclk_fall && !cs_high)     dout_q <= lo_q[0];
  end

  assign frame   = {hi_q, lo_q};
  assign dout    = dout_q;
  assign dout_oe = ~cs_high;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= OVER);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> $stable(frame));
  // R10
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_q == '0));
endmodule

// File: rtl/dacf_decode.sv
module dacf_decode
  import dacf_pkg::*;
#(
  parameter int FRAME_W      = 16,
  parameter int NUM_CH       = 12,
  parameter int SHARED_FIRST = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame,
  input  logic               frame_vld,
  output upd_t               upd,
  output logic               exp_vld,
  output logic [1:0]         exp_op,
  output logic [FRAME_W-SEL_W-1:0] exp_payload
);
  localparam int SET_W = FRAME_W - SEL_W;
  localparam int OP_W  = SET_W - CODE_W;
  localparam logic [SEL_W-1:0] LAST_SEL  = SEL_W'(NUM_CH);
  localparam logic [SEL_W-1:0] FIRST_SH  = SEL_W'(SHARED_FIRST);
  localparam logic [SET_W-1:0] HIZ_VAL   = SET_W'(1) << CODE_W;
  localparam logic [OP_W-1:0]  OP_BCAST  = OP_W'(1);
  localparam logic [OP_W-1:0]  OP_HIZALL = OP_W'(2);
  localparam logic [OP_W-1:0]  OP_RESET  = OP_W'(3);

  logic [SEL_W-1:0] sel;
  logic [SET_W-1:0] setting;
  logic [OP_W-1:0]  op;
  upd_t             nxt;
  logic             ex_n;

  assign sel     = frame[SEL_W-1:0];
  assign setting = frame[FRAME_W-1:SEL_W];
  assign op      = frame[FRAME_W-1 -: OP_W];

  always_comb begin
    nxt      = '0;
    nxt.kind = UPD_NONE;
    nxt.idx  = sel - 1'b1;
    nxt.code = frame[SEL_W +: CODE_W];
    ex_n     = 1'b0;
    if (frame_vld) begin
      if (sel == '0) begin
        case (op)
          OP_BCAST:  nxt.kind = UPD_ALL;
          OP_HIZALL: nxt.kind = UPD_HIZALL;
          OP_RESET:  nxt.kind = UPD_RST;
          default:   nxt.kind = UPD_NONE;
        endcase
      end else if (sel <= LAST_SEL) begin
        if (op == '0)
          nxt.kind = UPD_ONE;
        else if (setting == HIZ_VAL && sel >= FIRST_SH)
          nxt.kind = UPD_HIZ1;
      end else begin
        ex_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd         <= '0;
      exp_vld     <= 1'b0;
      exp_op      <= '0;
      exp_payload <= '0;
    end else begin
      upd     <= nxt;
      exp_vld <= ex_n;
      if (ex_n) begin
        exp_op      <= sel[1:0];
        exp_payload <= setting;
      end
    end
  end

  // R8
  exp_code_chk: assert property (@(posedge clk) disable iff (rst)
    exp_vld |-> (exp_op != 2'b00));
  // R8
  exp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exp_vld |=> !exp_vld);
endmodule

// File: rtl/dacf_bank.sv
module dacf_bank
  import dacf_pkg::*;
#(
  parameter int NUM_CH       = 12,
  parameter int SHARED_FIRST = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  upd_t                     upd,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic [NUM_CH-SHARED_FIRST:0] hiz
);
  localparam int NUM_SH = NUM_CH - SHARED_FIRST + 1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_code
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else begin
        case (upd.kind)
          UPD_ONE: if (upd.idx == SEL_W'(c)) code_q <= upd.code;
          UPD_ALL: code_q <= upd.code;
          UPD_RST: code_q <= '0;
          default: ;
        endcase
      end
    end
    assign codes[c*CODE_W +: CODE_W] = code_q;
  end

  for (genvar s = 0; s < NUM_SH; s++) begin : g_hiz
    localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(SHARED_FIRST - 1 + s);
    logic hiz_q;
    always_ff @(posedge clk) begin
      if (rst) hiz_q <= 1'b1;
      else begin
        case (upd.kind)
          UPD_ONE:    if (upd.idx == MY_IDX) hiz_q <= 1'b0;
          UPD_HIZ1:   if (upd.idx == MY_IDX) hiz_q <= 1'b1;
          UPD_ALL:    hiz_q <= 1'b0;
          UPD_HIZALL: hiz_q <= 1'b1;
          UPD_RST:    hiz_q <= 1'b1;
          default: ;
        endcase
      end
    end
    assign hiz[s] = hiz_q;
  end

  // R6
  hizall_keeps_codes_chk: assert property (@(posedge clk) disable iff (rst)
    (upd.kind == UPD_HIZALL) |=> ($stable(codes) && (&hiz)));
  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (upd.kind == UPD_RST) |=> ((codes == '0) && (&hiz)));
endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dacf_pkg::*;
#(
  parameter int FRAME_W      = 16,
  parameter int NUM_CH       = 12,
  parameter int SHARED_FIRST = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sclk_in,
  input  logic                           sdi_in,
  input  logic                           csn_in,
  output logic                           sdo,
  output logic                           sdo_oe,
  output logic [NUM_CH*CODE_W-1:0]       dac_code,
  output logic [NUM_CH-SHARED_FIRST:0]   shared_hiz,
  output logic                           exp_vld,
  output logic [1:0]                     exp_op,
  output logic [FRAME_W-SEL_W-1:0]       exp_payload
);
  localparam int NUM_IN = 3;  // 0: shift clock, 1: data, 2: chip-select

  logic [NUM_IN-1:0] raw, syn, rise, fall;
  logic [FRAME_W-1:0] frame;
  logic               frm_vld;
  upd_t               upd;

  assign raw = {csn_in, sdi_in, sclk_in};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    dacf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(i == 2)) u_sync (
      .clk(clk), .rst(rst), .d(raw[i]),
      .q(syn[i]), .rise(rise[i]), .fall(fall[i])
    );
  end

  dacf_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .din(syn[1]),
    .sclk_rise(rise[0]), .sclk_fall(fall[0]),
    .cs_high(syn[2]), .cs_fall(fall[2]), .cs_rise(rise[2]),
    .frame(frame), .frame_vld(frm_vld),
    .dout(sdo), .dout_oe(sdo_oe)
  );

  dacf_decode #(.FRAME_W(FRAME_W), .NUM_CH(NUM_CH), .SHARED_FIRST(SHARED_FIRST)) u_dec (
    .clk(clk), .rst(rst), .frame(frame), .frame_vld(frm_vld),
    .upd(upd), .exp_vld(exp_vld), .exp_op(exp_op), .exp_payload(exp_payload)
  );

  dacf_bank #(.NUM_CH(NUM_CH), .SHARED_FIRST(SHARED_FIRST)) u_bank (
    .clk(clk), .rst(rst), .upd(upd), .codes(dac_code), .hiz(shared_hiz)
  );

  // R2
  commit_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |-> $past(frm_vld, 2));
endmodule

// File: tb/sim_dac_frame_ctrl.sv
module sim_dac_frame_ctrl;
  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
  always #4 clk = ~clk;

  logic        sdo, sdo_oe, exp_vld;
  logic [95:0] dac_code;
  logic [7:0]  shared_hiz;
  logic [1:0]  exp_op;
  logic [11:0] exp_payload;

  dac_frame_ctrl u0 (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdi_in(sdi), .csn_in(csn),
    .sdo(sdo), .sdo_oe(sdo_oe), .dac_code(dac_code), .shared_hiz(shared_hiz),
    .exp_vld(exp_vld), .exp_op(exp_op), .exp_payload(exp_payload)
  );

  int n_chk = 0, n_fail = 0;
  logic [103:0] snap_q[$];
  string        tag_q[$];
  logic [13:0]  xq[$];
  string        xtag_q[$];
  logic [7:0]   m_code[12];
  logic [7:0]   m_hiz;
  logic [31:0]  cap;
  logic         oe_seen;

  task automatic check(string tag, logic [103:0] act, logic [103:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [103:0] model_snap();
    logic [103:0] s;
    s = '0;
    for (int c = 0; c < 12; c++) s[c*8 +: 8] = m_code[c];
    s[103:96] = m_hiz;
    return s;
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < 12; c++) m_code[c] = 8'h00;
    m_hiz = 8'hFF;
  endfunction

  function automatic void apply(logic [15:0] f, int n);
    logic [3:0] sel, op;
    logic [7:0] c;
    if (n != 16) return;
    sel = f[3:0]; op = f[15:12]; c = f[11:4];
    if (sel == 0) begin
      if (op == 1) begin
        for (int k = 0; k < 12; k++) m_code[k] = c;
        m_hiz = 8'h00;
      end else if (op == 2) m_hiz = 8'hFF;
      else if (op == 3) model_reset();
    end else if (sel <= 12) begin
      if (op == 0) begin
        m_code[sel-1] = c;
        if (sel >= 5) m_hiz[sel-5] = 1'b0;
      end else if (f[15:4] == 12'h100 && sel >= 5) m_hiz[sel-5] = 1'b1;
    end
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(logic [31:0] data, int n);
    csn = 1'b0; cyc(6);
    cap = '0; oe_seen = 1'b1;
    for (int i = 0; i < n; i++) begin
      sdi = data[i]; cyc(6);
      cap[i] = sdo;
      if (sdo_oe !== 1'b1) oe_seen = 1'b0;
      sclk = 1'b1; cyc(6);
      sclk = 1'b0;
    end
    cyc(6);
    csn = 1'b1; cyc(14);
  endtask

  task automatic frame(logic [15:0] f, int n, string tag);
    if (n == 16 && f[3:0] > 4'd12) begin
      xq.push_back({f[1:0], f[15:4]});
      xtag_q.push_back(tag);
    end
    send({16'h0000, f}, n);
    apply(f, n);
    snap_q.push_back(model_snap());
    tag_q.push_back(tag);
    cyc(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (snap_q.size() > 0)
      check(tag_q.pop_front(), {shared_hiz, dac_code}, snap_q.pop_front());
    if (exp_vld) begin
      if (xq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected strobe: actual %h expected none", {exp_op, exp_payload});
      end else
        check(xtag_q.pop_front(), {exp_op, exp_payload}, xq.pop_front());
    end
  end

  initial begin
    model_reset();
    cyc(5);
    rst = 1'b0;
    cyc(3);
    snap_q.push_back(model_snap()); tag_q.push_back("R10 reset state");
    check("R9 oe low when idle", sdo_oe, 1'b0);
    cyc(2);

    frame({4'h0, 8'h3C, 4'h1}, 16, "R3 R1 ch1 write");
    frame({4'h0, 8'hA5, 4'hC}, 16, "R3 ch12 write clears hiz");
    frame({4'h0, 8'h11, 4'h7}, 16, "R3 ch7 write");
    frame({12'h100, 4'h7}, 16, "R4 ch7 hiz");
    frame({12'h100, 4'h2}, 16, "R4 ch2 hiz no effect");
    frame({4'h5, 8'h77, 4'h3}, 16, "R4 unknown setting ignored");
    frame({4'h1, 8'h80, 4'h0}, 16, "R5 broadcast");
    frame({4'h2, 8'h00, 4'h0}, 16, "R6 all shared hiz");
    frame({4'h7, 8'h55, 4'h0}, 16, "R7 unknown special ignored");
    frame({4'h0, 8'h99, 4'h1}, 15, "R2 short frame discarded");
    frame({4'h0, 8'h99, 4'h1}, 17, "R2 long frame discarded");
    frame({12'hABC, 4'hD}, 16, "R8 expander 13");
    frame({12'h5A3, 4'hE}, 16, "R8 expander 14");
    frame({12'h0F1, 4'hF}, 16, "R8 expander 15");

    frame({4'h0, 8'h5A, 4'h4}, 16, "R3 ch4 write");
    frame({4'h0, 8'hC3, 4'h3}, 16, "R3 ch3 write");
    check("R9 chained output", {16'h0, cap[15:0]}, {4'h0, 8'h5A, 4'h4});
    check("R9 oe high in frame", oe_seen, 1'b1);
    check("R9 oe low after frame", sdo_oe, 1'b0);

    frame({4'h3, 8'h00, 4'h0}, 16, "R7 soft reset");

    frame({4'h0, 8'hBE, 4'h2}, 16, "R3 ch2 write");
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(3);
    model_reset();
    snap_q.push_back(model_snap()); tag_q.push_back("R10 reset after writes");
    cyc(2);
    frame(16'h0000, 16, "R7 ignored frame");
    check("R10 low byte kept", cap[7:0], 8'hE2);
    check("R10 high byte cleared", cap[15:8], 8'h00);

    cyc(20);
    check("R8 all strobes seen", xq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule